// File: doc/BRIEF.md
# Register-Array LIFO Stack with Full and Empty Flags

This block is a hardware last-in, first-out store of 64 words held in flip-flops and addressed by a 6-bit stack pointer. A client asks for a push or a pop on single-cycle request lines. A push carries a data word in. A pop returns the top word on a registered data output, and that output keeps its value until the next successful pop.

The pointer moves up before a push writes, and it moves down after a pop reads. The full and empty flags have no separate occupancy count behind them. Each flag is raised when the pointer wraps to zero: after a push the stack is full, and after a pop it is empty.

The block refuses an operation it cannot perform and reports it. A push into a full stack, a pop from an empty stack, and a push and pop requested in the same cycle each leave the state unchanged. Each one raises its own one-cycle error pulse. The data width is a parameter. The pointer width sets the depth.

Top module: `reg_stack`

## Requirements
- R1: After reset, sp_o is 0, empty_o is 1, full_o is 0, data_o is 0 and all three error outputs are 0.
- R2: A push alone into a stack that is not full does two things at the sampling edge: sp_o becomes sp_o+1 modulo 64, and data_i is stored in the word at the new pointer. It also clears empty_o.
- R3: A legal push that takes sp_o from 63 to 0 sets full_o.
- R4: A pop alone from a stack that is not empty does two things at the sampling edge: data_o takes the word at the current sp_o, and sp_o then becomes sp_o-1. It also clears full_o.
- R5: A legal pop that takes sp_o from 1 to 0 sets empty_o.
- R6: Pops return words in the reverse of the order in which they were pushed, including after all 64 words are filled.
- R7: A push while full_o is 1 changes no state, and ovf_err_o is 1 for exactly the following cycle.
- R8: A pop while empty_o is 1 changes no state, and unf_err_o is 1 for exactly the following cycle.
- R9: push_i and pop_i both high in one cycle changes no state. Only clash_err_o pulses, whatever the flags are.
- R10: data_o changes only on a legal pop. Every other cycle leaves it unchanged.
- R11: full_o and empty_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| data_i | input | DATA_W | Word to push |
| data_o | output | DATA_W | Last popped word |
| sp_o | output | PTR_W | Stack pointer |
| full_o | output | 1 | Stack holds 64 words |
| empty_o | output | 1 | Stack holds no words |
| ovf_err_o | output | 1 | Pulse: push refused because full |
| unf_err_o | output | 1 | Pulse: pop refused because empty |
| clash_err_o | output | 1 | Pulse: push and pop requested together |

## Verification
Every result is due one rising edge after the request that causes it: the pointer, both flags, the popped word and the error pulses. No output lags further behind. The bench changes requests on the falling edge and compares all outputs at the next falling edge. At that point the edge that sampled the request has gone by and the next one has not yet come. The error pulses are also checked to drop again one cycle after an idle or legal request. The expected values come from a bench-side LIFO model that advances once per request.

// File: rtl/reg_stack_pkg.sv
package reg_stack_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_CLASH = 2'd3
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    case ({push, pop})
      2'b10:   return OP_PUSH;
      2'b01:   return OP_POP;
      2'b11:   return OP_CLASH;
      default: return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/reg_stack_ptr_ctrl.sv
module reg_stack_ptr_ctrl
  import reg_stack_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  output logic [PTR_W-1:0] sp_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             do_push_o,
  output logic             do_pop_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             clash_o
);

  logic [PTR_W-1:0] sp_q, sp_inc, sp_dec;
  logic             full_q, empty_q;
  logic             ovf_q, unf_q, clash_q;

  assign sp_inc    = sp_q + PTR_W'(1);
  assign sp_dec    = sp_q - PTR_W'(1);
  assign do_push_o = (op_i == OP_PUSH) && !full_q;
  assign do_pop_o  = (op_i == OP_POP) && !empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      clash_q <= 1'b0;
    end else begin
      ovf_q   <= (op_i == OP_PUSH) && full_q;
      unf_q   <= (op_i == OP_POP) && empty_q;
      clash_q <= (op_i == OP_CLASH);
      if (do_push_o) begin
        sp_q    <= sp_inc;
        full_q  <= (sp_inc == '0);  // wrap to zero marks the last free word used
        empty_q <= 1'b0;
      end else if (do_pop_o) begin
        sp_q    <= sp_dec;
        empty_q <= (sp_dec == '0);
        full_q  <= 1'b0;
      end
    end
  end

  assign sp_o     = sp_q;
  assign wr_ptr_o = sp_inc;
  assign full_o   = full_q;
  assign empty_o  = empty_q;
  assign ovf_o    = ovf_q;
  assign unf_o    = unf_q;
  assign clash_o  = clash_q;

endmodule

// File: rtl/reg_stack_regs.sv
module reg_stack_regs #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words[g] <= '0;
      end else if (we_i && (waddr_i == PTR_W'(g))) begin
        words[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = words[raddr_i];

endmodule

// File: rtl/reg_stack.sv
module reg_stack
  import reg_stack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [PTR_W-1:0]  sp_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovf_err_o,
  output logic              unf_err_o,
  output logic              clash_err_o
);

  stk_op_e           op;
  logic [PTR_W-1:0]  sp, wr_ptr;
  logic              do_push, do_pop;
  logic [DATA_W-1:0] top_word;
  logic [DATA_W-1:0] dout_q;

  assign op = decode_op(push_i, pop_i);

  reg_stack_ptr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .sp_o      (sp),
    .wr_ptr_o  (wr_ptr),
    .do_push_o (do_push),
    .do_pop_o  (do_pop),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .ovf_o     (ovf_err_o),
    .unf_o     (unf_err_o),
    .clash_o   (clash_err_o)
  );

  reg_stack_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (do_push),
    .waddr_i (wr_ptr),
    .wdata_i (data_i),
    .raddr_i (sp),
    .rdata_o (top_word)
  );

  // read at the pre-decrement pointer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dout_q <= '0;
    else if (do_pop) dout_q <= top_word;
  end

  assign data_o = dout_q;
  assign sp_o   = sp;

endmodule

// File: rtl/reg_stack_chk.sv
module reg_stack_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic [PTR_W-1:0]  sp_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              ovf_err_o,
  input logic              unf_err_o,
  input logic              clash_err_o
);

  logic lpush, lpop;
  assign lpush = push_i && !pop_i && !full_o;
  assign lpop  = pop_i && !push_i && !empty_o;

  p_push_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpush |=> (sp_o == PTR_W'($past(sp_o) + PTR_W'(1))) && !empty_o);

  p_full_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpush && (sp_o == '1)) |=> full_o);

  p_pop_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpop |=> (sp_o == PTR_W'($past(sp_o) - PTR_W'(1))) && !full_o);

  p_empty_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpop && (sp_o == PTR_W'(1))) |=> empty_o);

  p_lifo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lpush) && pop_i && !push_i) |=> (data_o == $past(data_i, 2)));

  p_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> ovf_err_o && full_o && $stable(sp_o));

  p_unf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> unf_err_o && empty_o && $stable(sp_o));

  p_clash_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> clash_err_o && !ovf_err_o && !unf_err_o &&
      $stable(sp_o) && $stable(full_o) && $stable(empty_o) && $stable(data_o));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lpop |=> $stable(data_o));

  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  p_err_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_err_o, unf_err_o, clash_err_o}));

endmodule

bind reg_stack reg_stack_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .data_i      (data_i),
  .data_o      (data_o),
  .sp_o        (sp_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .ovf_err_o   (ovf_err_o),
  .unf_err_o   (unf_err_o),
  .clash_err_o (clash_err_o)
);

// File: tb/reg_stack_tb.sv
module reg_stack_tb;

  localparam int DW    = 8;
  localparam int PW    = 6;
  localparam int DEPTH = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0, pop_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic [PW-1:0] sp_o;
  logic          full_o, empty_o, ovf_err_o, unf_err_o, clash_err_o;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [PW-1:0] m_sp;
  logic          m_full, m_empty, m_ovf, m_unf, m_clash;
  logic [DW-1:0] m_dout;

  always #10 clk = ~clk;  // 50 MHz

  reg_stack #(.DATA_W(DW), .PTR_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
    .data_i(data_i), .data_o(data_o), .sp_o(sp_o), .full_o(full_o),
    .empty_o(empty_o), .ovf_err_o(ovf_err_o), .unf_err_o(unf_err_o),
    .clash_err_o(clash_err_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic push, input logic pop, input logic [DW-1:0] din);
    m_ovf   = push && !pop && m_full;
    m_unf   = pop && !push && m_empty;
    m_clash = push && pop;
    if (push && !pop && !m_full) begin
      m_sp = m_sp + PW'(1);
      m_mem[m_sp] = din;
      m_empty = 1'b0;
      m_full  = (m_sp == '0);
    end else if (pop && !push && !m_empty) begin
      m_dout  = m_mem[m_sp];
      m_sp    = m_sp - PW'(1);
      m_full  = 1'b0;
      m_empty = (m_sp == '0);
    end
  endtask

  // called at a falling edge; compares at the next falling edge
  task automatic do_op(input logic push, input logic pop, input logic [DW-1:0] din);
    string t_sp, t_dat;
    logic  was_full, was_empty;
    was_full  = m_full;
    was_empty = m_empty;
    push_i = push; pop_i = pop; data_i = din;
    if (push && pop)                    begin t_sp = "R9";  t_dat = "R9";  end
    else if (push && was_full)          begin t_sp = "R7";  t_dat = "R10"; end
    else if (pop && was_empty)          begin t_sp = "R8";  t_dat = "R10"; end
    else if (push)                      begin t_sp = "R2";  t_dat = "R10"; end
    else if (pop)                       begin t_sp = "R4";  t_dat = "R6";  end
    else                                begin t_sp = "R10"; t_dat = "R10"; end
    model_step(push, pop, din);
    @(posedge clk);
    @(negedge clk);
    chk(t_sp,  "sp_o",        32'(sp_o),        32'(m_sp));
    chk(t_dat, "data_o",      32'(data_o),      32'(m_dout));
    chk("R3",  "full_o",      32'(full_o),      32'(m_full));
    chk("R5",  "empty_o",     32'(empty_o),     32'(m_empty));
    chk("R7",  "ovf_err_o",   32'(ovf_err_o),   32'(m_ovf));
    chk("R8",  "unf_err_o",   32'(unf_err_o),   32'(m_unf));
    chk("R9",  "clash_err_o", 32'(clash_err_o), 32'(m_clash));
    chk("R11", "flags_excl",  32'(full_o && empty_o), 32'(0));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog all_reqs actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20250611));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_sp = '0; m_full = 1'b0; m_empty = 1'b1; m_dout = '0;
    m_ovf = 1'b0; m_unf = 1'b0; m_clash = 1'b0;

    repeat (3) @(negedge clk);
    chk("R1", "sp_o reset",    32'(sp_o),    32'(0));
    chk("R1", "empty_o reset", 32'(empty_o), 32'(1));
    chk("R1", "full_o reset",  32'(full_o),  32'(0));
    chk("R1", "data_o reset",  32'(data_o),  32'(0));
    chk("R1", "errs reset",    32'({ovf_err_o, unf_err_o, clash_err_o}), 32'(0));
    rst_ni = 1'b1;
    @(negedge clk);

    // underflow on empty, then idle pulse drop
    do_op(1'b0, 1'b1, 8'h00);
    do_op(1'b0, 1'b0, 8'h00);
    // clash on empty
    do_op(1'b1, 1'b1, 8'hAA);
    // fill to full: 64th push wraps pointer to 0
    for (int i = 0; i < DEPTH; i++) do_op(1'b1, 1'b0, DW'(8'h40 + i * 3));
    chk("R3", "full after 64 pushes", 32'(full_o), 32'(1));
    chk("R3", "sp wrapped",           32'(sp_o),   32'(0));
    // overflow twice, clash while full
    do_op(1'b1, 1'b0, 8'hEE);
    do_op(1'b1, 1'b0, 8'hEF);
    do_op(1'b1, 1'b1, 8'h11);
    // drain all 64 in reverse order
    for (int i = DEPTH - 1; i >= 0; i--) begin
      do_op(1'b0, 1'b1, 8'h00);
      chk("R6", "lifo order", 32'(data_o), 32'(DW'(8'h40 + i * 3)));
    end
    chk("R5", "empty after drain", 32'(empty_o), 32'(1));
    // data_o holds across refused and idle cycles
    do_op(1'b0, 1'b1, 8'h00);
    do_op(1'b1, 1'b0, 8'h5A);
    do_op(1'b0, 1'b0, 8'h00);
    chk("R10", "hold after push", 32'(data_o), 32'(8'h40));
    do_op(1'b0, 1'b1, 8'h00);
    chk("R6", "push-pop pair", 32'(data_o), 32'(8'h5A));

    // random: push-heavy then pop-heavy phases
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 400; n++) begin
        int r;
        r = int'($urandom % 16);
        if (ph % 2 == 0) begin
          if (r < 10)      do_op(1'b1, 1'b0, DW'($urandom));
          else if (r < 13) do_op(1'b0, 1'b1, DW'($urandom));
          else if (r < 14) do_op(1'b1, 1'b1, DW'($urandom));
          else             do_op(1'b0, 1'b0, DW'($urandom));
        end else begin
          if (r < 4)       do_op(1'b1, 1'b0, DW'($urandom));
          else if (r < 13) do_op(1'b0, 1'b1, DW'($urandom));
          else if (r < 14) do_op(1'b1, 1'b1, DW'($urandom));
          else             do_op(1'b0, 1'b0, DW'($urandom));
        end
      end
    end

    push_i = 1'b0; pop_i = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule